// File: doc/BRIEF.md
# External Master Access Bridge

This block lets a second bus master on the external bus reach slaves on the on-chip internal bus. It decodes every external address against an internal window whose base is relocatable. On a hit it either serves the access itself, if the target is its own mode register, or passes a single transfer onto the internal bus. It closes each accepted access with one terminating pulse on the external bus: acknowledge, error or retry. Bursts are rejected.

A two-bit mode register selects how the external master shares the chip with the core:
- **Halt mode:** the core is stopped and receives no internal-bus grants.
- **Shared mode:** the core keeps running and both masters use the internal bus in whatever order their requests arrive.

The register can be written by core software or by the external master. A configuration input sampled during reset can start the chip in halt mode.

The bridge also breaks one deadlock. If the core has an outbound access pending when an external access arrives, the bridge retries the external master. It then withholds core grants for a fixed window so that pending traffic can drain.

Top module: `xmb_bridge`

## Requirements
- R1: The mode register holds the halt bit in bit 0 and the shared bit in bit 1. Reset loads halt = `boot_halt_i` and shared = 0. The register sits at window offset `REG_OFS` (default 0) and is always reachable, whatever the mode. A read returns the bits zero-extended. An external write takes `ext_wdata_i[1:0]`. Either access is acknowledged in the cycle after the start.
- R2: `core_halt_o` equals the halt bit. While it is high, `core_gnt_o` stays low.
- R3: Shared mode is shared bit = 1 with halt bit = 0; in it `core_halt_o` is low and window hits are forwarded. With both bits clear, a non-register hit ends with an error and no internal request.
- R4: A core configuration write updates the register unless the halt bit is set, in which case it is ignored. An external register write in the same cycle wins over the core write.
- R5: A burst hit (`ext_burst_i` = 1) ends with `ext_tea_o` and `ext_bi_o` both pulsed in the next cycle, and no internal request is made.
- R6: Size codes are 0 = 8 bit, 1 = 16 bit, 2 = 32 bit, and these are forwarded unchanged on `ib_size_o`. Code 3 ends with an error.
- R7: An address hits when `ext_addr_i[AW-1:AW-BASE_W]` equals `win_base_i`. A miss produces no termination and no internal request.
- R8: A start is ignored unless `ext_owner_i` is high. A start is also ignored while a forwarded access is still in progress.
- R9: A forwarded access raises `ib_req_o` in the cycle after the start, carrying the address, direction, size and data. `ib_req_o` is held until `ib_ack_i` or `ib_err_i` arrives. The next cycle then gives `ext_ta_o` with `ib_rdata_i` on `ext_rdata_o`, or gives `ext_tea_o`. Error wins if both arrive together.
- R10: Each accepted access yields exactly one of `ext_ta_o`, `ext_tea_o` or `ext_retry_o`. No two are ever high together.
- R11: A hit that starts while `core_out_pend_i` is high gets `ext_retry_o` in the next cycle and no internal request. `core_gnt_o` is then low for the 8 cycles starting with the retry cycle.
- R12: Hit checks are applied in this order: burst, bad size, pending core access, register, mode enabled.
- R13: Otherwise `core_gnt_o` follows `core_req_i`, with no priority against forwarded external traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| boot_halt_i | input | 1 | Reset-time selection of halt mode |
| win_base_i | input | BASE_W | Internal window base |
| ext_start_i | input | 1 | External transfer start |
| ext_owner_i | input | 1 | External master holds the bus |
| ext_addr_i | input | AW | External address |
| ext_we_i | input | 1 | External write |
| ext_size_i | input | 2 | Transfer size code |
| ext_burst_i | input | 1 | Burst attempt |
| ext_wdata_i | input | DW | External write data |
| ext_ta_o | output | 1 | Transfer acknowledge |
| ext_tea_o | output | 1 | Transfer error |
| ext_retry_o | output | 1 | Retry |
| ext_bi_o | output | 1 | Burst inhibit |
| ext_rdata_o | output | DW | Read data |
| ib_req_o | output | 1 | Internal bus request |
| ib_addr_o | output | AW | Internal address |
| ib_we_o | output | 1 | Internal write |
| ib_size_o | output | 2 | Internal size code |
| ib_wdata_o | output | DW | Internal write data |
| ib_ack_i | input | 1 | Internal acknowledge |
| ib_err_i | input | 1 | Internal error |
| ib_rdata_i | input | DW | Internal read data |
| core_req_i | input | 1 | Core wants the internal bus |
| core_out_pend_i | input | 1 | Core has an outbound access pending |
| core_gnt_o | output | 1 | Core grant |
| core_halt_o | output | 1 | Core halt |
| core_cfg_we_i | input | 1 | Core write to mode register |
| core_cfg_wdata_i | input | 2 | Core mode write data |

## Verification
Two pairs of functions can land on the same clock edge.

The first pair is a core software write to the mode register and an external write to it. The bench pulses `core_cfg_we_i` in the same cycle as an external register write. It then reads the register back through the window and expects the external value. The same read-back, done while halted, shows that a lone core write was dropped.

The second pair is a deadlock retry and a burst or register hit. The bench raises `core_out_pend_i` together with such a hit. It expects the priority of R12, and it counts the cycles of lost core grant after a retry.

// File: rtl/xmb_pkg.sv
package xmb_pkg;
  typedef enum logic [1:0] {TERM_NONE, TERM_ACK, TERM_ERR, TERM_RETRY} term_e;
  typedef enum logic {ST_IDLE, ST_FWD} st_e;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;
  localparam logic [1:0] SZ_BAD  = 2'd3;

  typedef struct packed {
    logic shared;
    logic halt;
  } mode_t;
endpackage

// File: rtl/xmb_mode_reg.sv
module xmb_mode_reg
  import xmb_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       boot_halt_i,
  input  logic       ext_we_i,
  input  logic [1:0] ext_wdata_i,
  input  logic       core_we_i,
  input  logic [1:0] core_wdata_i,
  output mode_t      mode_o,
  output logic       halt_o,
  output logic       shared_o
);
  mode_t mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q.shared <= 1'b0;
      mode_q.halt   <= boot_halt_i;
    end else if (ext_we_i) begin
      mode_q <= mode_t'(ext_wdata_i);
    end else if (core_we_i && !mode_q.halt) begin
      mode_q <= mode_t'(core_wdata_i);
    end
  end

  assign mode_o   = mode_q;
  assign halt_o   = mode_q.halt;
  assign shared_o = mode_q.shared & ~mode_q.halt;

  AST_HALTED_CORE_WRITE_DROPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ext_we_i && core_we_i && mode_q.halt) |=> $stable(mode_q)); // R4
  AST_EXT_WRITE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_we_i |=> (mode_q == mode_t'($past(ext_wdata_i)))); // R4
endmodule

// File: rtl/xmb_window.sv
module xmb_window #(
  parameter int AW      = 32,
  parameter int BASE_W  = 8,
  parameter int REG_OFS = 0
) (
  input  logic [AW-1:0]     addr_i,
  input  logic [BASE_W-1:0] base_i,
  output logic              hit_o,
  output logic              reg_hit_o
);
  localparam int OFS_W = AW - BASE_W;

  assign hit_o     = (addr_i[AW-1:OFS_W] == base_i);
  assign reg_hit_o = hit_o && (addr_i[OFS_W-1:0] == OFS_W'(REG_OFS));
endmodule

// File: rtl/xmb_lockout.sv
module xmb_lockout #(
  parameter int LOCK_CYC = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  output logic busy_o
);
  localparam int CNT_W = (LOCK_CYC < 1) ? 1 : $clog2(LOCK_CYC + 1);

  generate
    if (LOCK_CYC == 0) begin : g_none
      assign busy_o = 1'b0;
    end else begin : g_cnt
      logic [CNT_W-1:0] cnt_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          cnt_q <= '0;
        end else if (arm_i) begin
          cnt_q <= CNT_W'(LOCK_CYC);
        end else if (cnt_q != '0) begin
          cnt_q <= cnt_q - 1'b1;
        end
      end

      assign busy_o = (cnt_q != '0);

      AST_LOCK_ARMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        arm_i |=> busy_o); // R11
      AST_LOCK_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!arm_i && cnt_q == CNT_W'(1)) |=> !busy_o); // R11
    end
  endgenerate
endmodule

// File: rtl/xmb_bridge.sv
module xmb_bridge
  import xmb_pkg::*;
#(
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter int BASE_W   = 8,
  parameter int REG_OFS  = 0,
  parameter int LOCK_CYC = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              boot_halt_i,
  input  logic [BASE_W-1:0] win_base_i,
  input  logic              ext_start_i,
  input  logic              ext_owner_i,
  input  logic [AW-1:0]     ext_addr_i,
  input  logic              ext_we_i,
  input  logic [1:0]        ext_size_i,
  input  logic              ext_burst_i,
  input  logic [DW-1:0]     ext_wdata_i,
  output logic              ext_ta_o,
  output logic              ext_tea_o,
  output logic              ext_retry_o,
  output logic              ext_bi_o,
  output logic [DW-1:0]     ext_rdata_o,
  output logic              ib_req_o,
  output logic [AW-1:0]     ib_addr_o,
  output logic              ib_we_o,
  output logic [1:0]        ib_size_o,
  output logic [DW-1:0]     ib_wdata_o,
  input  logic              ib_ack_i,
  input  logic              ib_err_i,
  input  logic [DW-1:0]     ib_rdata_i,
  input  logic              core_req_i,
  input  logic              core_out_pend_i,
  output logic              core_gnt_o,
  output logic              core_halt_o,
  input  logic              core_cfg_we_i,
  input  logic [1:0]        core_cfg_wdata_i
);
  st_e           st_q;
  term_e         term_d, term_q;
  logic          bi_d, bi_q;
  logic [DW-1:0] rdata_d, rdata_q;
  logic          hit, reg_hit, take, go_fwd, reg_wr, arm, lock_busy;
  logic          halt, shared;
  mode_t         mode;

  xmb_window #(.AW(AW), .BASE_W(BASE_W), .REG_OFS(REG_OFS)) i_window (
    .addr_i    (ext_addr_i),
    .base_i    (win_base_i),
    .hit_o     (hit),
    .reg_hit_o (reg_hit)
  );

  xmb_mode_reg i_mode (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .boot_halt_i  (boot_halt_i),
    .ext_we_i     (reg_wr),
    .ext_wdata_i  (ext_wdata_i[1:0]),
    .core_we_i    (core_cfg_we_i),
    .core_wdata_i (core_cfg_wdata_i),
    .mode_o       (mode),
    .halt_o       (halt),
    .shared_o     (shared)
  );

  xmb_lockout #(.LOCK_CYC(LOCK_CYC)) i_lock (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .arm_i  (arm),
    .busy_o (lock_busy)
  );

  assign take = (st_q == ST_IDLE) && ext_start_i && ext_owner_i && hit;

  // checks in fixed priority: burst, size, deadlock, own register, mode
  always_comb begin
    term_d  = TERM_NONE;
    bi_d    = 1'b0;
    go_fwd  = 1'b0;
    reg_wr  = 1'b0;
    arm     = 1'b0;
    rdata_d = '0;
    if (take) begin
      if (ext_burst_i) begin
        term_d = TERM_ERR;
        bi_d   = 1'b1;
      end else if (ext_size_i == SZ_BAD) begin
        term_d = TERM_ERR;
      end else if (core_out_pend_i) begin
        term_d = TERM_RETRY;
        arm    = 1'b1;
      end else if (reg_hit) begin
        term_d  = TERM_ACK;
        reg_wr  = ext_we_i;
        rdata_d = DW'(mode);
      end else if (!(halt || shared)) begin
        term_d = TERM_ERR;
      end else begin
        go_fwd = 1'b1;
      end
    end else if (st_q == ST_FWD && (ib_ack_i || ib_err_i)) begin
      term_d  = ib_err_i ? TERM_ERR : TERM_ACK;
      rdata_d = ib_err_i ? '0 : ib_rdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      term_q  <= TERM_NONE;
      bi_q    <= 1'b0;
      rdata_q <= '0;
    end else begin
      term_q  <= term_d;
      bi_q    <= bi_d;
      rdata_q <= rdata_d;
      if (go_fwd)
        st_q <= ST_FWD;
      else if (st_q == ST_FWD && (ib_ack_i || ib_err_i))
        st_q <= ST_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ib_req_o   <= 1'b0;
      ib_addr_o  <= '0;
      ib_we_o    <= 1'b0;
      ib_size_o  <= SZ_BYTE;
      ib_wdata_o <= '0;
    end else if (go_fwd) begin
      ib_req_o   <= 1'b1;
      ib_addr_o  <= ext_addr_i;
      ib_we_o    <= ext_we_i;
      ib_size_o  <= ext_size_i;
      ib_wdata_o <= ext_wdata_i;
    end else if (ib_ack_i || ib_err_i) begin
      ib_req_o <= 1'b0;
    end
  end

  assign ext_ta_o    = (term_q == TERM_ACK);
  assign ext_tea_o   = (term_q == TERM_ERR);
  assign ext_retry_o = (term_q == TERM_RETRY);
  assign ext_bi_o    = bi_q;
  assign ext_rdata_o = rdata_q;
  assign core_halt_o = halt;
  assign core_gnt_o  = core_req_i && !halt && !lock_busy;

  AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ib_req_o && !ib_ack_i && !ib_err_i) |=> (ib_req_o && $stable(ib_addr_o))); // R9
  AST_BI_WITH_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_bi_o |-> ext_tea_o); // R5
  AST_RETRY_BLOCKS_CORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_retry_o |-> !core_gnt_o); // R11
  AST_REJECT_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_retry_o || ext_bi_o) |-> !ib_req_o); // R11
  AST_HALT_NO_GNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_halt_o |-> !core_gnt_o); // R2
  AST_FWD_NO_TERM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ib_req_o && $past(ib_req_o)) |-> !(ext_ta_o || ext_tea_o || ext_retry_o)); // R10
endmodule

// File: tb/test_xmb_bridge.sv
module test_xmb_bridge;
  localparam int E_NONE = 0, E_ACK = 1, E_ERR = 2, E_RTY = 3, E_FWD = 4;

  logic        clk = 1'b0, rst_ni = 1'b0, boot_halt_i = 1'b0;
  logic [7:0]  win_base_i = 8'hA5;
  logic        ext_start_i = 0, ext_owner_i = 0, ext_we_i = 0, ext_burst_i = 0;
  logic [31:0] ext_addr_i = '0, ext_wdata_i = '0;
  logic [1:0]  ext_size_i = '0;
  logic        ext_ta_o, ext_tea_o, ext_retry_o, ext_bi_o;
  logic [31:0] ext_rdata_o;
  logic        ib_req_o, ib_we_o;
  logic [31:0] ib_addr_o, ib_wdata_o;
  logic [1:0]  ib_size_o;
  logic        ib_ack_i = 0, ib_err_i = 0;
  logic [31:0] ib_rdata_i = '0;
  logic        core_req_i = 0, core_out_pend_i = 0, core_gnt_o, core_halt_o;
  logic        core_cfg_we_i = 0;
  logic [1:0]  core_cfg_wdata_i = '0;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit m_halt = 0, m_shared = 0;

  always #5 clk = ~clk;

  xmb_bridge i_xmb_bridge (
    .clk_i(clk), .rst_ni(rst_ni), .boot_halt_i(boot_halt_i), .win_base_i(win_base_i),
    .ext_start_i(ext_start_i), .ext_owner_i(ext_owner_i), .ext_addr_i(ext_addr_i),
    .ext_we_i(ext_we_i), .ext_size_i(ext_size_i), .ext_burst_i(ext_burst_i),
    .ext_wdata_i(ext_wdata_i), .ext_ta_o(ext_ta_o), .ext_tea_o(ext_tea_o),
    .ext_retry_o(ext_retry_o), .ext_bi_o(ext_bi_o), .ext_rdata_o(ext_rdata_o),
    .ib_req_o(ib_req_o), .ib_addr_o(ib_addr_o), .ib_we_o(ib_we_o), .ib_size_o(ib_size_o),
    .ib_wdata_o(ib_wdata_o), .ib_ack_i(ib_ack_i), .ib_err_i(ib_err_i),
    .ib_rdata_i(ib_rdata_i), .core_req_i(core_req_i), .core_out_pend_i(core_out_pend_i),
    .core_gnt_o(core_gnt_o), .core_halt_o(core_halt_o), .core_cfg_we_i(core_cfg_we_i),
    .core_cfg_wdata_i(core_cfg_wdata_i)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  function automatic int predict(logic [31:0] a, bit burst, logic [1:0] sz, bit pend, bit own);
    if (!own || a[31:24] != win_base_i) return E_NONE;  // R7 R8
    if (burst) return E_ERR;                            // R5 R12
    if (sz == 2'd3) return E_ERR;                       // R6
    if (pend) return E_RTY;                             // R11
    if (a[23:0] == 24'd0) return E_ACK;                 // R1
    if (!(m_halt || m_shared)) return E_ERR;            // R3
    return E_FWD;
  endfunction

  function automatic logic [31:0] reg_addr();
    return {win_base_i, 24'd0};
  endfunction

  // caller is aligned on a falling edge
  task automatic access(input logic [31:0] a, input bit we, input logic [31:0] wd,
                        input logic [1:0] sz, input bit burst, input bit own, input bit pend,
                        input int dly, input bit err, input bit cfg_we, input logic [1:0] cfg_d,
                        input bit poke, input string tag);
    int e;
    logic [31:0] rd;
    e = predict(a, burst, sz, pend, own);
    rd = $urandom;
    ext_start_i = 1; ext_addr_i = a; ext_we_i = we; ext_wdata_i = wd; ext_size_i = sz;
    ext_burst_i = burst; ext_owner_i = own; core_out_pend_i = pend;
    core_cfg_we_i = cfg_we; core_cfg_wdata_i = cfg_d;
    @(negedge clk);
    ext_start_i = 0; core_cfg_we_i = 0; core_out_pend_i = 0;
    case (e)
      E_NONE: begin
        chk(tag, "no term", {ext_ta_o, ext_tea_o, ext_retry_o}, 0);
        chk(tag, "no ib_req", ib_req_o, 0);
      end
      E_ACK: begin
        chk(tag, "reg ta", {ext_ta_o, ext_tea_o, ext_retry_o}, 3'b100);
        chk(tag, "reg rdata", ext_rdata_o, {30'd0, m_shared, m_halt});
      end
      E_ERR: begin
        chk(tag, "tea", {ext_ta_o, ext_tea_o, ext_retry_o}, 3'b010);
        chk(tag, "bi", ext_bi_o, burst);
        chk(tag, "no ib_req", ib_req_o, 0);
      end
      E_RTY: begin
        chk(tag, "retry", {ext_ta_o, ext_tea_o, ext_retry_o}, 3'b001);
        chk(tag, "no ib_req", ib_req_o, 0);
        chk(tag, "gnt blocked", core_gnt_o, 0);
      end
      default: begin
        chk(tag, "ib_req", ib_req_o, 1);
        chk(tag, "ib_addr", ib_addr_o, a);
        chk(tag, "ib_size", ib_size_o, sz);
        chk(tag, "ib_we", ib_we_o, we);
        if (we) chk(tag, "ib_wdata", ib_wdata_o, wd);
        chk(tag, "no early term", {ext_ta_o, ext_tea_o, ext_retry_o}, 0);
        for (int i = 0; i < dly; i++) begin
          if (poke && i == 0) begin
            ext_start_i = 1; ext_addr_i = reg_addr(); ext_owner_i = 1; ext_burst_i = 0;
            ext_size_i = 2'd2;
          end
          @(negedge clk);
          ext_start_i = 0;
          chk(poke ? "R8" : "R9", "wait", {ib_req_o, ext_ta_o, ext_tea_o, ext_retry_o}, 4'b1000);
        end
        ib_rdata_i = rd;
        if (err) ib_err_i = 1; else ib_ack_i = 1;
        @(negedge clk);
        ib_ack_i = 0; ib_err_i = 0;
        chk("R9", "fwd term", {ext_ta_o, ext_tea_o, ext_retry_o}, err ? 3'b010 : 3'b100);
        if (!err) chk("R9", "fwd rdata", ext_rdata_o, rd);
        chk("R9", "req dropped", ib_req_o, 0);
      end
    endcase
    if (e == E_ACK && we) {m_shared, m_halt} = wd[1:0];
    else if (cfg_we && !m_halt) {m_shared, m_halt} = cfg_d;
    if (e != E_FWD) chk("R2", "halt out", core_halt_o, m_halt);
  endtask

  task automatic core_write(input logic [1:0] d);
    core_cfg_we_i = 1; core_cfg_wdata_i = d;
    @(negedge clk);
    core_cfg_we_i = 0;
    if (!m_halt) {m_shared, m_halt} = d;
    chk("R4", "core write halt", core_halt_o, m_halt);
  endtask

  task automatic read_reg(input string tag);
    access(reg_addr(), 0, 0, 2'd2, 0, 1, 0, 0, 0, 0, 2'd0, 0, tag);
  endtask

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    chk("R1", "reset term", {ext_ta_o, ext_tea_o, ext_retry_o, ib_req_o}, 0);
    rst_ni = 1;
    @(negedge clk);
    chk("R1", "reset halt", core_halt_o, 0);
    core_req_i = 1;
    #1 chk("R13", "gnt follows req", core_gnt_o, 1);
    @(negedge clk);

    read_reg("R1");
    access({8'hA5, 24'h000100}, 0, 0, 2'd2, 0, 1, 0, 0, 0, 0, 2'd0, 0, "R3");
    core_write(2'b10);
    chk("R3", "shared no halt", core_halt_o, 0);
    access({8'hA5, 24'h000104}, 0, 0, 2'd2, 0, 1, 0, 2, 0, 0, 2'd0, 0, "R9");
    chk("R13", "gnt while forwarding", core_gnt_o, 1);
    access({8'hA5, 24'h000200}, 1, 32'hDEADBEEF, 2'd1, 0, 1, 0, 1, 1, 0, 2'd0, 0, "R9");
    access({8'hA5, 24'h000300}, 1, 32'h12, 2'd0, 0, 1, 0, 3, 0, 0, 2'd0, 1, "R8");
    access({8'h11, 24'h000100}, 0, 0, 2'd2, 0, 1, 0, 0, 0, 0, 2'd0, 0, "R7");
    access({8'hA5, 24'h000100}, 0, 0, 2'd2, 0, 0, 0, 0, 0, 0, 2'd0, 0, "R8");
    access({8'hA5, 24'h000100}, 0, 0, 2'd2, 1, 1, 0, 0, 0, 0, 2'd0, 0, "R5");
    access({8'hA5, 24'h000100}, 0, 0, 2'd3, 0, 1, 0, 0, 0, 0, 2'd0, 0, "R6");
    access({8'hA5, 24'h000100}, 0, 0, 2'd2, 1, 1, 1, 0, 0, 0, 2'd0, 0, "R12");
    access(reg_addr(), 0, 0, 2'd2, 0, 1, 1, 0, 0, 0, 2'd0, 0, "R12");
    for (int i = 1; i < 8; i++) begin
      @(negedge clk);
      chk("R11", "lockout window", core_gnt_o, 0);
    end
    @(negedge clk);
    chk("R11", "lockout over", core_gnt_o, 1);

    access(reg_addr(), 1, 32'h1, 2'd2, 0, 1, 0, 0, 0, 0, 2'd0, 0, "R1");
    chk("R2", "halt gnt", core_gnt_o, 0);
    core_write(2'b00);
    read_reg("R4");
    access({8'hA5, 24'h000400}, 0, 0, 2'd2, 0, 1, 0, 1, 0, 0, 2'd0, 0, "R2");
    access(reg_addr(), 1, 32'h2, 2'd2, 0, 1, 0, 0, 0, 0, 2'd0, 0, "R3");
    access(reg_addr(), 1, 32'h1, 2'd2, 0, 1, 0, 0, 0, 1, 2'b10, 0, "R4");
    read_reg("R4");
    access(reg_addr(), 1, 32'h2, 2'd2, 0, 1, 0, 0, 0, 0, 2'd0, 0, "R4");

    core_req_i = 0;
    for (int n = 0; n < 400; n++) begin
      logic [31:0] a;
      int r;
      if (n == 200) win_base_i = 8'h3C;
      r = $urandom % 6;
      if (r == 0) a = reg_addr();
      else if (r == 1) a = {win_base_i ^ 8'h81, 24'($urandom)};
      else a = {win_base_i, 24'($urandom % 64) << 2};
      if ($urandom % 10 == 0) core_write(2'($urandom));
      access(a, 1'($urandom), $urandom, 2'($urandom), ($urandom % 8) == 0,
             ($urandom % 8) != 0, ($urandom % 8) == 0, $urandom % 4, ($urandom % 5) == 0,
             ($urandom % 8) == 0, 2'($urandom), 0, "R10");
    end

    boot_halt_i = 1;
    rst_ni = 0;
    @(negedge clk);
    rst_ni = 1;
    m_halt = 1; m_shared = 0;
    @(negedge clk);
    chk("R1", "boot halt", core_halt_o, 1);
    read_reg("R1");

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule